// File: doc/BRIEF.md
# Prescaled Free-Running Interval Counter

This block is an 8-bit up-counter that runs as long as the chip is out of reset and has no stop control. It advances once per count pulse. The pulse comes either from a power-of-two divider on the main clock or, when software selects it, from rising edges of a slow external RC clock. Each time the counter rolls over from 0xFF to 0x00, the block raises a sticky interrupt request. On the same cycle it emits a one-cycle tick toward a neighbouring watchdog.

Software reaches the block through a single bus location. A read of that location returns the live counter. A write to it loads a control byte. That byte holds the divide select, a counter-clear bit that drops back to zero by itself, the source select, and two mode bits that only leave the block as outputs. The control byte cannot be read back, so software must always write a complete byte and never rely on read-modify-write.

Top module: `ivt_timer`

## Requirements
- R1: After reset, `rd_data` is 0x00, `irq_flag` and `wdt_tick` are 0, `mode_wdt_on` is 1, `mode_wakeup` is 0, the divide select is 111 (one count every 1024 clocks) and the prescaled source is in use.
- R2: With control bit 5 at 0, control bits [2:0] = s make the counter advance by exactly one every 2^(s+3) clocks: 000 gives 8, 001 gives 16, 010 gives 32, 011 gives 64, 100 gives 128, 101 gives 256, 110 gives 512 and 111 gives 1024. `rd_data` always shows the counter.
- R3: When the counter steps from 0xFF to 0x00, `irq_flag` becomes 1 and `wdt_tick` is 1 for exactly one cycle. Both are seen in the same cycle as `rd_data` = 0x00.
- R4: `irq_flag` stays 1 until a cycle with `irq_ack` = 1, and it reads 0 in the following cycle.
- R5: If `irq_ack` and a wrap happen in the same cycle, `irq_flag` stays 1.
- R6: A write with bit 3 = 1 makes `rd_data` read 0x00 in the second cycle after the write edge. The clear bit returns to 0 by itself, so counting then resumes without further writes.
- R7: If the clear takes effect in the same cycle as a count pulse, the clear wins. The counter reads 0x00 until the next count pulse, which moves it to 0x01.
- R8: With control bit 5 = 1, the counter advances once per rising edge of `rc_clk_in`, after a two-flop synchronizer, and ignores the prescaler.
- R9: Control bit 6 drives `mode_wakeup` and control bit 4 drives `mode_wdt_on`. Both take the written value one cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Control byte: [6] wake-up mode, [5] RC source, [4] watchdog mode, [3] clear, [2:0] divide select, [7] ignored |
| rd_data | output | 8 | Current counter value |
| rc_clk_in | input | 1 | Asynchronous slow RC clock used as the alternate count source |
| irq_ack | input | 1 | Clears the interrupt request |
| irq_flag | output | 1 | Sticky interrupt request set on counter wrap |
| wdt_tick | output | 1 | One-cycle pulse on counter wrap, toward the watchdog |
| mode_wdt_on | output | 1 | Watchdog-enable mode bit |
| mode_wakeup | output | 1 | Wake-up timer mode bit |

## Verification
The control register updates on the write edge, so the mode outputs are checked at the next falling edge. The counter is cleared one edge later, so the clear is checked one falling edge after that. A wrap shows `rd_data` = 0x00, `irq_flag` and `wdt_tick` together, one register after the count pulse. Because the ÷8 prescaler runs freely, the bench first observes a counter step and then counts exactly eight edges, which puts an acknowledge or a clear on the same edge as the next pulse. An RC edge passes three registers before it counts, so those checks leave several cycles of margin.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

  parameter int unsigned IVT_SEL_W = 3;

  // Control byte bits [6:0]; bit 7 carries nothing
  typedef struct packed {
    logic                 wakeup;
    logic                 rc_sel;
    logic                 wdt_on;
    logic                 clr;
    logic [IVT_SEL_W-1:0] sel;
  } ivt_ctrl_t;

  localparam int unsigned IVT_CTRL_W = $bits(ivt_ctrl_t);

  localparam ivt_ctrl_t IVT_CTRL_RST = '{
    wakeup: 1'b0,
    rc_sel: 1'b0,
    wdt_on: 1'b1,
    clr:    1'b0,
    sel:    {IVT_SEL_W{1'b1}}
  };

endpackage

// File: rtl/ivt_prescaler.sv
module ivt_prescaler #(
  parameter int unsigned SEL_W     = 3,
  parameter int unsigned MIN_SHIFT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);

  localparam int unsigned NUM_TAPS = 1 << SEL_W;
  localparam int unsigned DIV_W    = NUM_TAPS - 1 + MIN_SHIFT;

  logic [DIV_W-1:0]    div_q;
  logic [DIV_W-1:0]    div_d;
  logic [NUM_TAPS-1:0] taps;

  always_comb begin
    div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else begin
      div_q <= div_d;
    end
  end

  // Tap g fires once per 2^(g+MIN_SHIFT) clocks, when its low bits are all ones
  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
    assign taps[g] = &div_q[g+MIN_SHIFT-1:0];
  end

  assign tick = taps[sel];

endmodule

// File: rtl/ivt_rc_sync.sv
module ivt_rc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rc_in,
  output logic rise
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], rc_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/ivt_ctrl_reg.sv
module ivt_ctrl_reg
  import ivt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  ivt_ctrl_t wr_val,
  output ivt_ctrl_t ctrl_q
);

  ivt_ctrl_t ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) begin
      ctrl_d = wr_val;
    end else if (ctrl_q.clr) begin
      ctrl_d.clr = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= IVT_CTRL_RST;
    end else begin
      ctrl_q <= ctrl_d;
    end
  end

endmodule

// File: rtl/ivt_counter.sv
module ivt_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             cnt_en,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap
);

  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (cnt_en) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  assign wrap = cnt_en & ~clr & (&cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/ivt_irq.sv
module ivt_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic wrap,
  input  logic ack,
  output logic flag_q,
  output logic tick_q
);

  logic flag_d;

  always_comb begin
    flag_d = wrap | (flag_q & ~ack);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
      tick_q <= wrap;
    end
  end

endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
  import ivt_pkg::*;
#(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned MIN_SHIFT = 3,
  parameter int unsigned RC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] rd_data,
  input  logic             rc_clk_in,
  input  logic             irq_ack,
  output logic             irq_flag,
  output logic             wdt_tick,
  output logic             mode_wdt_on,
  output logic             mode_wakeup
);

  localparam int unsigned SPARE_W = CNT_W - IVT_CTRL_W;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  ivt_ctrl_t  ctrl_q;
  ivt_ctrl_t  wr_val;
  logic       pre_tick;
  logic       rc_tick;
  logic       cnt_en;
  logic       wrap;
  logic       clr_pulse;
  logic [SPARE_W-1:0] unused_spare;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  assign wr_val       = ivt_ctrl_t'(wr_data[IVT_CTRL_W-1:0]);
  assign unused_spare = wr_data[CNT_W-1:IVT_CTRL_W];

  ivt_ctrl_reg u_ctrl (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .wr_en  (wr_en),
    .wr_val (wr_val),
    .ctrl_q (ctrl_q)
  );

  ivt_prescaler #(
    .SEL_W     (IVT_SEL_W),
    .MIN_SHIFT (MIN_SHIFT)
  ) u_pre (
    .clk   (clk),
    .rst_n (rst_int_n),
    .sel   (ctrl_q.sel),
    .tick  (pre_tick)
  );

  ivt_rc_sync #(
    .STAGES (RC_STAGES)
  ) u_rc (
    .clk   (clk),
    .rst_n (rst_int_n),
    .rc_in (rc_clk_in),
    .rise  (rc_tick)
  );

  assign cnt_en    = ctrl_q.rc_sel ? rc_tick : pre_tick;
  assign clr_pulse = ctrl_q.clr;

  ivt_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .clr    (clr_pulse),
    .cnt_en (cnt_en),
    .cnt_q  (rd_data),
    .wrap   (wrap)
  );

  ivt_irq u_irq (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .wrap   (wrap),
    .ack    (irq_ack),
    .flag_q (irq_flag),
    .tick_q (wdt_tick)
  );

  assign mode_wdt_on = ctrl_q.wdt_on;
  assign mode_wakeup = ctrl_q.wakeup;

endmodule

// File: rtl/ivt_checker.sv
module ivt_checker #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_int_n,
  input logic             wr_en,
  input logic [CNT_W-1:0] wr_data,
  input logic [CNT_W-1:0] rd_data,
  input logic             irq_ack,
  input logic             irq_flag,
  input logic             wdt_tick,
  input logic             mode_wdt_on,
  input logic             mode_wakeup,
  input logic             clr_pulse
);

  AST_TICK_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
    wdt_tick |-> (rd_data == '0)); // R3

  AST_TICK_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_int_n)
    wdt_tick |-> irq_flag); // R3

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    wdt_tick |=> !wdt_tick); // R3

  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_int_n)
    (irq_flag && !irq_ack) |=> irq_flag); // R4

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_en && wr_data[3]) |=> ##1 (rd_data == '0)); // R6

  AST_CLEAR_SELF_DROP: assert property (@(posedge clk) disable iff (!rst_int_n)
    (clr_pulse && !wr_en) |=> !clr_pulse); // R6

  AST_MODE_WDT: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_en |=> (mode_wdt_on == $past(wr_data[4]))); // R9

  AST_MODE_WAKE: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_en |=> (mode_wakeup == $past(wr_data[6]))); // R9

endmodule

bind ivt_timer ivt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_int_n   (rst_int_n),
  .wr_en       (wr_en),
  .wr_data     (wr_data),
  .rd_data     (rd_data),
  .irq_ack     (irq_ack),
  .irq_flag    (irq_flag),
  .wdt_tick    (wdt_tick),
  .mode_wdt_on (mode_wdt_on),
  .mode_wakeup (mode_wakeup),
  .clr_pulse   (clr_pulse)
);

// File: tb/sim_ivt_timer.sv
`timescale 1ns/1ps
module sim_ivt_timer;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       rc_clk_in;
  logic       irq_ack;
  logic       irq_flag;
  logic       wdt_tick;
  logic       mode_wdt_on;
  logic       mode_wakeup;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  ivt_timer u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .rd_data     (rd_data),
    .rc_clk_in   (rc_clk_in),
    .irq_ack     (irq_ack),
    .irq_flag    (irq_flag),
    .wdt_tick    (wdt_tick),
    .mode_wdt_on (mode_wdt_on),
    .mode_wakeup (mode_wakeup)
  );

  // {select, expected clocks per count}
  localparam logic [15:0] VEC [8] = '{
    {4'd0, 12'd8},   {4'd1, 12'd16},  {4'd2, 12'd32},  {4'd3, 12'd64},
    {4'd4, 12'd128}, {4'd5, 12'd256}, {4'd6, 12'd512}, {4'd7, 12'd1024}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en   = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic wait_change(output int cyc);
    logic [7:0] prev;
    prev = rd_data;
    cyc  = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (rd_data == prev && cyc < 5000);
  endtask

  task automatic wait_ff();
    int guard;
    guard = 0;
    while (rd_data != 8'hFF && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int c;
    rst_n = 1'b0; wr_en = 1'b0; wr_data = 8'h00; rc_clk_in = 1'b0; irq_ack = 1'b0;
    step(4);
    rst_n = 1'b1;
    step(3);

    // R1: reset state
    chk(rd_data == 8'h00, "R1 rd_data", rd_data, 0);
    chk(irq_flag == 1'b0, "R1 irq_flag", irq_flag, 0);
    chk(wdt_tick == 1'b0, "R1 wdt_tick", wdt_tick, 0);
    chk(mode_wdt_on == 1'b1, "R1 mode_wdt_on", mode_wdt_on, 1);
    chk(mode_wakeup == 1'b0, "R1 mode_wakeup", mode_wakeup, 0);
    wait_change(c);
    wait_change(c);
    chk(c == 1024, "R1 reset divide", c, 1024);

    // R2: table of divide selects
    for (int i = 0; i < 8; i++) begin
      wr(8'h18 | {5'd0, VEC[i][14:12]});
      step(2);
      wait_change(c);
      wait_change(c);
      chk(c == int'(VEC[i][11:0]), "R2 divide period", c, int'(VEC[i][11:0]));
    end

    // R6: clear then self-release
    wr(8'h10);
    step(30);
    wr(8'h18);
    step(1);
    chk(rd_data == 8'h00, "R6 clear to zero", rd_data, 0);
    step(40);
    chk(rd_data != 8'h00, "R6 counting resumes", rd_data, 5);

    // R7: clear on the same edge as a count pulse
    wait_change(c);
    step(6);
    wr(8'h18);
    step(1);
    chk(rd_data == 8'h00, "R7 clear wins", rd_data, 0);
    step(7);
    chk(rd_data == 8'h00, "R7 holds zero", rd_data, 0);
    step(1);
    chk(rd_data == 8'h01, "R7 next pulse", rd_data, 1);

    // R3 and R4: wrap raises flag and tick
    wait_ff();
    step(8);
    chk(rd_data == 8'h00, "R3 wrap value", rd_data, 0);
    chk(irq_flag == 1'b1, "R3 irq set", irq_flag, 1);
    chk(wdt_tick == 1'b1, "R3 tick high", wdt_tick, 1);
    step(1);
    chk(wdt_tick == 1'b0, "R3 tick one cycle", wdt_tick, 0);
    step(20);
    chk(irq_flag == 1'b1, "R4 irq held", irq_flag, 1);

    // R5: acknowledge coincident with wrap
    wait_ff();
    step(7);
    irq_ack = 1'b1;
    step(1);
    irq_ack = 1'b0;
    chk(wdt_tick == 1'b1, "R5 wrap occurred", wdt_tick, 1);
    chk(irq_flag == 1'b1, "R5 flag kept", irq_flag, 1);

    // R4: acknowledge alone
    irq_ack = 1'b1;
    step(1);
    irq_ack = 1'b0;
    chk(irq_flag == 1'b0, "R4 ack clears", irq_flag, 0);

    // R8: RC source
    wr(8'h38);
    step(2);
    for (int k = 0; k < 5; k++) begin
      rc_clk_in = 1'b1;
      step(6);
      rc_clk_in = 1'b0;
      step(6);
    end
    step(4);
    chk(rd_data == 8'h05, "R8 rc edges counted", rd_data, 5);
    step(2000);
    chk(rd_data == 8'h05, "R8 prescaler ignored", rd_data, 5);

    // R9: mode outputs
    wr(8'h47);
    chk(mode_wakeup == 1'b1, "R9 wakeup set", mode_wakeup, 1);
    chk(mode_wdt_on == 1'b0, "R9 wdt_on clear", mode_wdt_on, 0);
    wr(8'h17);
    chk(mode_wakeup == 1'b0, "R9 wakeup clear", mode_wakeup, 0);
    chk(mode_wdt_on == 1'b1, "R9 wdt_on set", mode_wdt_on, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule